// File: doc/BRIEF.md
# Task-File Register Port for an 8-bit PIO Storage Card

This block lets a host reach the eight task-file registers and the device-control register of a storage card that runs in true-IDE mode over an 8-bit programmed-I/O bus. The host gives one request at a time: a register index, a direction, a data byte and a burst flag. The block turns the request into a timed bus cycle. It holds the register select steady for a set-up window and then drives one active-low strobe for a set pulse width. A read samples the card's data byte while the strobe is still low. A write drives the byte out with the output enable before the strobe falls.

A single-register access moves one byte. A burst access moves a whole sector through the data register with back-to-back strobes. During a burst the block exposes the index of the current byte, and the host supplies the matching write byte combinationally. After its own reset the block holds the card's reset line low for a set time. It then releases the line and waits a further settle time before it accepts any request.

All eight control lines come from one registered byte. From the top bit down it holds card reset, write strobe, read strobe, and a five-bit select made of two chip selects and three address bits.

Top module: `cf_taskfile_port`

## Requirements
- R1: After `rst` falls, `ctrl_out[7]` (card reset, active low) stays 0 for exactly `RST_LOW_CYC` cycles while both strobes stay high. `req_ready` then stays low for a further `RST_WAIT_CYC` cycles. While `rst` is high, `ctrl_out` reads 0x70, and `dbus_oe`, `done` and `req_ready` are 0.
- R2: `ctrl_out[4:0]` during an access follows from the register index. Indices 0 to 7 give `{2'b10, index[2:0]}` (0x10 to 0x17). Indices 8 to 15 all give the device-control select 0x0E.
- R3: Once out of the power-up phase and idle, `ctrl_out[7:5]` is 3'b111. Before the first access the select is the data register, so `ctrl_out` = 0xF0.
- R4: For a read (`req_write`=0), the select is applied for `SETUP_CYC` cycles with `ctrl_out[5]` high. `ctrl_out[5]` is then low for `PULSE_CYC` cycles. `dbus_in` is sampled on the last low cycle. `done` pulses for one cycle, one cycle after `ctrl_out[5]` returns high, and `rdata` holds the sampled byte in that cycle.
- R5: For a write, `dbus_oe` rises one cycle after the select is applied, with `dbus_out` equal to the write byte. `ctrl_out[6]` falls after `SETUP_CYC` select cycles and stays low for `PULSE_CYC` cycles. `dbus_oe` is still 1 in the cycle `ctrl_out[6]` rises and is 0 in the next cycle, which is the `done` cycle.
- R6: `dbus_oe` is never 1 during a read access, including while `ctrl_out[5]` is low.
- R7: A request is accepted on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access (or the whole burst) ends. It is 1 again in the cycle of the final `done` pulse.
- R8: With `req_burst`=1, exactly `BURST_BYTES` (512) strobes run, all on select 0x10, whatever `req_reg` holds. Each byte gives one `done` pulse. For reads, `rdata` carries the bytes in bus order. `done_last` is 1 only together with the final `done`.
- R9: During a burst write, `bst_idx` counts 0 to `BURST_BYTES-1`, one step per byte. The byte driven on `dbus_out` for the k-th strobe is the value of `bst_wdata` taken while `bst_idx` equals k.
- R10: The two strobes (`ctrl_out[6]` and `ctrl_out[5]`) are never low together. `ctrl_out[4:0]` does not change while either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = sector burst on the data register |
| req_reg | input | 4 | Register index (0-7 task file, 8-15 device control) |
| req_wdata | input | 8 | Write byte for a single access |
| done | output | 1 | One-cycle pulse per completed byte |
| done_last | output | 1 | Final byte of a burst, with `done` |
| rdata | output | 8 | Byte read, valid with `done` |
| bst_idx | output | 9 | Index of the current burst byte |
| bst_wdata | input | 8 | Burst write byte for `bst_idx` |
| ctrl_out | output | 8 | {reset_n, wr_n, rd_n, select[4:0]} |
| dbus_out | output | 8 | Data bus output value |
| dbus_oe | output | 1 | Data bus output enable |
| dbus_in | input | 8 | Data bus input value |

## Verification
In a burst, the `done` pulse for byte k falls in the same cycle as the first set-up cycle of byte k+1. In that cycle the output enable must be released and the byte counter must already have moved on. The bench runs a full 512-byte burst write against a card model that records the bus at each write-strobe rise. It checks that every recorded byte matches the pattern for its index, and that `dbus_oe` is low in each `done` cycle between bytes. In the same way, the final `done` coincides with `req_ready` coming back. The bench checks that `req_ready` is high in the `done_last` cycle and low in every cycle of the burst before it.

// File: rtl/cf_port_pkg.sv
`timescale 1ns/1ps
package cf_port_pkg;

  localparam int CTRL_RST_BIT = 7;
  localparam int CTRL_WR_BIT  = 6;
  localparam int CTRL_RD_BIT  = 5;

  localparam logic [4:0] SEL_DATA   = 5'h10;
  localparam logic [4:0] SEL_DEVCTL = 5'h0E;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RISE
  } seq_st_t;

  // Task-file index to the combined chip-select/address field.
  function automatic logic [4:0] sel_code(input logic [3:0] idx);
    if (idx[3]) return SEL_DEVCTL;
    return {2'b10, idx[2:0]};
  endfunction

endpackage

// File: rtl/cf_port_powerup.sv
`timescale 1ns/1ps
module cf_port_powerup #(
  parameter int RST_LOW_CYC  = 2000000,
  parameter int RST_WAIT_CYC = 4000000
) (
  input  logic clk,
  input  logic rst,
  output logic card_rst_n,
  output logic up_ok
);
  localparam int MAXC  = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOW_END  = CW'(RST_LOW_CYC - 1);
  localparam logic [CW-1:0] WAIT_END = CW'(RST_WAIT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      card_rst_n <= 1'b0;
      up_ok      <= 1'b0;
    end else if (!card_rst_n) begin
      if (cnt == LOW_END) begin
        card_rst_n <= 1'b1;
        cnt        <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (!up_ok) begin
      if (cnt == WAIT_END) up_ok <= 1'b1;
      else                 cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cf_port_byte_ctr.sv
`timescale 1ns/1ps
module cf_port_byte_ctr #(
  parameter int BURST_BYTES = 512,
  localparam int IDX_W = $clog2(BURST_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) idx <= '0;
    else if (step)    idx <= idx + 1'b1;
  end

  assign last = (idx == LAST_IDX);
endmodule

// File: rtl/cf_port_strobe_seq.sv
`timescale 1ns/1ps
module cf_port_strobe_seq
  import cf_port_pkg::*;
#(
  parameter int SETUP_CYC = 3,
  parameter int PULSE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       up_ok,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic       req_burst,
  input  logic [3:0] req_reg,
  input  logic [7:0] req_wdata,
  input  logic       idx_last,
  output logic       ctr_clear,
  output logic       ctr_step,
  input  logic [7:0] bst_wdata,
  input  logic [7:0] dbus_in,
  output logic       iowr_n,
  output logic       iord_n,
  output logic [4:0] sel,
  output logic [7:0] dbus_out,
  output logic       dbus_oe,
  output logic       done,
  output logic       done_last,
  output logic [7:0] rdata
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_END = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);

  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic          wr_q, bur_q;
  logic [7:0]    wd_q;
  logic          accept;

  assign req_ready = up_ok && (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ctr_clear = accept;
  assign ctr_step  = (st == ST_RISE) && bur_q && !idx_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      bur_q     <= 1'b0;
      wd_q      <= '0;
      iowr_n    <= 1'b1;
      iord_n    <= 1'b1;
      sel       <= SEL_DATA;
      dbus_out  <= 8'hFF;
      dbus_oe   <= 1'b0;
      done      <= 1'b0;
      done_last <= 1'b0;
      rdata     <= '0;
    end else begin
      done      <= 1'b0;
      done_last <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            wr_q  <= req_write;
            bur_q <= req_burst;
            wd_q  <= req_wdata;
            sel   <= req_burst ? SEL_DATA : sel_code(req_reg);
            cnt   <= '0;
            st    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          // Second select cycle onward: write byte on the bus.
          if (cnt == '0 && wr_q) begin
            dbus_oe  <= 1'b1;
            dbus_out <= bur_q ? bst_wdata : wd_q;
          end
          if (cnt == SETUP_END) begin
            cnt <= '0;
            st  <= ST_STROBE;
            if (wr_q) iowr_n <= 1'b0;
            else      iord_n <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt == PULSE_END) begin
            if (!wr_q) rdata <= dbus_in;
            iowr_n <= 1'b1;
            iord_n <= 1'b1;
            cnt    <= '0;
            st     <= ST_RISE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RISE: begin
          done     <= 1'b1;
          dbus_oe  <= 1'b0;
          dbus_out <= 8'hFF;
          cnt      <= '0;
          if (bur_q && !idx_last) begin
            st <= ST_SETUP;
          end else begin
            done_last <= bur_q;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cf_taskfile_port.sv
`timescale 1ns/1ps
module cf_taskfile_port
  import cf_port_pkg::*;
#(
  parameter int SETUP_CYC    = 3,
  parameter int PULSE_CYC    = 3,
  parameter int BURST_BYTES  = 512,
  parameter int RST_LOW_CYC  = 2000000,
  parameter int RST_WAIT_CYC = 4000000,
  localparam int IDX_W = $clog2(BURST_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_burst,
  input  logic [3:0]       req_reg,
  input  logic [7:0]       req_wdata,
  output logic             done,
  output logic             done_last,
  output logic [7:0]       rdata,
  output logic [IDX_W-1:0] bst_idx,
  input  logic [7:0]       bst_wdata,
  output logic [7:0]       ctrl_out,
  output logic [7:0]       dbus_out,
  output logic             dbus_oe,
  input  logic [7:0]       dbus_in
);
  logic       card_rst_n, up_ok;
  logic       ctr_clear, ctr_step, idx_last;
  logic       iowr_n, iord_n;
  logic [4:0] sel;

  cf_port_powerup #(
    .RST_LOW_CYC (RST_LOW_CYC),
    .RST_WAIT_CYC(RST_WAIT_CYC)
  ) pwr_i (
    .clk       (clk),
    .rst       (rst),
    .card_rst_n(card_rst_n),
    .up_ok     (up_ok)
  );

  cf_port_byte_ctr #(
    .BURST_BYTES(BURST_BYTES)
  ) ctr_i (
    .clk  (clk),
    .rst  (rst),
    .clear(ctr_clear),
    .step (ctr_step),
    .idx  (bst_idx),
    .last (idx_last)
  );

  cf_port_strobe_seq #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .up_ok    (up_ok),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_burst(req_burst),
    .req_reg  (req_reg),
    .req_wdata(req_wdata),
    .idx_last (idx_last),
    .ctr_clear(ctr_clear),
    .ctr_step (ctr_step),
    .bst_wdata(bst_wdata),
    .dbus_in  (dbus_in),
    .iowr_n   (iowr_n),
    .iord_n   (iord_n),
    .sel      (sel),
    .dbus_out (dbus_out),
    .dbus_oe  (dbus_oe),
    .done     (done),
    .done_last(done_last),
    .rdata    (rdata)
  );

  assign ctrl_out = {card_rst_n, iowr_n, iord_n, sel};
endmodule

// File: rtl/cf_taskfile_port_chk.sv
`timescale 1ns/1ps
module cf_taskfile_port_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctrl_out,
  input logic       dbus_oe,
  input logic       done,
  input logic       done_last,
  input logic       req_ready
);
  logic rst_n_l, wr_n, rd_n;
  assign rst_n_l = ctrl_out[7];
  assign wr_n    = ctrl_out[6];
  assign rd_n    = ctrl_out[5];

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(!wr_n && !rd_n));

  assert_sel_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_n || !rd_n) |-> $stable(ctrl_out[4:0]));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    !(dbus_oe && !rd_n));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !rst_n_l |-> (wr_n && rd_n && !req_ready && !dbus_oe));

  assert_done_after_rd_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |=> done);

  assert_oe_release_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |=> (done && !dbus_oe));

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (wr_n && rd_n && !dbus_oe));

  assert_last_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_last |-> done);
endmodule

bind cf_taskfile_port cf_taskfile_port_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .ctrl_out (ctrl_out),
  .dbus_oe  (dbus_oe),
  .done     (done),
  .done_last(done_last),
  .req_ready(req_ready)
);

// File: tb/cf_taskfile_port_tb_top.sv
`timescale 1ns/1ps
module cf_taskfile_port_tb_top;
  localparam int SETUP  = 3;
  localparam int PULSE  = 4;
  localparam int BYTES  = 512;
  localparam int RLOW   = 10;
  localparam int RWAIT  = 20;

  logic       clk = 0;
  logic       rst = 1;
  logic       req_valid = 0, req_write = 0, req_burst = 0;
  logic [3:0] req_reg = 0;
  logic [7:0] req_wdata = 0;
  logic       req_ready, done, done_last, dbus_oe;
  logic [7:0] rdata, ctl, dbus_out, dbus_in, bst_wdata;
  logic [8:0] bst_idx;

  int tests = 0, fails = 0;
  int rd_ptr = 0;
  logic iord_q = 1;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] wpat(input logic [8:0] i);
    return 8'(i * 5 + 1) ^ (i[8] ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [7:0] dpat(input int p);
    return 8'(p * 7 + 3);
  endfunction

  assign bst_wdata = wpat(bst_idx);
  // Card model: data register streams a sequence, others return a tag.
  assign dbus_in = !ctl[5] ? ((ctl[4:0] == 5'h10) ? dpat(rd_ptr) : {3'b101, ctl[4:0]})
                           : 8'hFF;

  always @(posedge clk) begin
    iord_q <= ctl[5];
    if (!iord_q && ctl[5] && ctl[4:0] == 5'h10) rd_ptr <= rd_ptr + 1;
  end

  cf_taskfile_port #(
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .BURST_BYTES(BYTES),
    .RST_LOW_CYC(RLOW), .RST_WAIT_CYC(RWAIT)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_reg(req_reg),
    .req_wdata(req_wdata), .done(done), .done_last(done_last), .rdata(rdata),
    .bst_idx(bst_idx), .bst_wdata(bst_wdata), .ctrl_out(ctl),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe), .dbus_in(dbus_in)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_sel(input logic [3:0] r);
    return r[3] ? 5'h0E : {2'b10, r[2:0]};
  endfunction

  // One single-register access, observed at negedges.
  task automatic access(input logic [3:0] r, input logic w, input logic [7:0] d,
                        output int su, output int pw, output int gap,
                        output logic [4:0] adr, output logic [7:0] rd,
                        output int oe_bad, output int dmis, output logic oe_rise,
                        output logic oe_done, output int busy_rdy);
    oe_bad = 0; dmis = 0; busy_rdy = 0; su = 0; pw = 0; gap = 0;
    @(negedge clk);
    req_valid = 1; req_reg = r; req_write = w; req_wdata = d; req_burst = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while ((w ? ctl[6] : ctl[5]) && su < 50) begin
      if (req_ready) busy_rdy++;
      if (!w && dbus_oe) oe_bad++;
      su++; @(negedge clk);
    end
    adr = ctl[4:0];
    while (!(w ? ctl[6] : ctl[5]) && pw < 50) begin
      if (req_ready) busy_rdy++;
      if (!w && dbus_oe) oe_bad++;
      if (w && (!dbus_oe || dbus_out != d)) dmis++;
      pw++; @(negedge clk);
    end
    oe_rise = dbus_oe;
    if (req_ready) busy_rdy++;
    while (!done && gap < 10) begin gap++; @(negedge clk); end
    oe_done = dbus_oe;
    rd = rdata;
  endtask

  task automatic t_reset;
    int n;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ctl == 8'h70 && !dbus_oe && !done && !req_ready, "R1 reset state", ctl, 8'h70);
    rst = 0;
    n = 0;
    while (!ctl[7] && n < 100) begin
      @(negedge clk); n++;
      if (!ctl[7] && (!ctl[6] || !ctl[5])) check(0, "R1 strobe in hold", ctl, 8'h70);
    end
    check(n == RLOW, "R1 reset low width", n, RLOW);
    while (!req_ready && n < 200) begin @(negedge clk); n++; end
    check(n == RLOW + RWAIT, "R1 settle before ready", n, RLOW + RWAIT);
    check(ctl == 8'hF0, "R3 idle control byte", ctl, 8'hF0);
  endtask

  task automatic t_reads;
    int su, pw, gap, ob, dm, br; logic [4:0] a; logic [7:0] rd; logic o1, o2;
    logic [3:0] regs [5] = '{4'd1, 4'd3, 4'd7, 4'd8, 4'd12};
    foreach (regs[i]) begin
      access(regs[i], 0, 8'h00, su, pw, gap, a, rd, ob, dm, o1, o2, br);
      check(a == exp_sel(regs[i]), "R2 read select", a, exp_sel(regs[i]));
      check(su == SETUP && pw == PULSE, "R4 read setup/pulse", su * 256 + pw, SETUP * 256 + PULSE);
      check(gap == 1, "R4 done one cycle after rise", gap, 1);
      check(rd == {3'b101, exp_sel(regs[i])}, "R4 read data", rd, {3'b101, exp_sel(regs[i])});
      check(ob == 0 && !o1 && !o2, "R6 no drive on read", ob, 0);
      check(br == 0, "R7 ready low while busy", br, 0);
    end
    begin
      int base; base = rd_ptr;
      access(4'd0, 0, 8'h00, su, pw, gap, a, rd, ob, dm, o1, o2, br);
      check(rd == dpat(base), "R4 data register read", rd, dpat(base));
    end
  endtask

  task automatic t_writes;
    int su, pw, gap, ob, dm, br; logic [4:0] a; logic [7:0] rd; logic o1, o2;
    for (int r = 0; r < 9; r++) begin
      logic [7:0] v; v = 8'(r * 17 + 1);
      access(4'(r), 1, v, su, pw, gap, a, rd, ob, dm, o1, o2, br);
      check(a == exp_sel(4'(r)), "R2 write select", a, exp_sel(4'(r)));
      check(su == SETUP && pw == PULSE, "R5 write setup/pulse", su * 256 + pw, SETUP * 256 + PULSE);
      check(dm == 0, "R5 write data on bus", dm, 0);
      check(o1 && !o2 && gap == 1, "R5 oe release after rise", {o1, o2, 8'(gap)}, 10'h201);
      check(br == 0, "R7 ready low while busy", br, 0);
    end
  endtask

  task automatic t_burst(input logic w);
    int strobes = 0, dones = 0, lastpos = -1, lastcnt = 0;
    int abad = 0, obad = 0, rbad = 0, rmis = 0, wmis = 0, wk = 0, gapoe = 0, n = 0;
    int base; logic pr; logic rdy_end;
    @(negedge clk);
    req_valid = 1; req_burst = 1; req_write = w; req_reg = 4'd3;
    while (!req_ready) @(negedge clk);
    base = rd_ptr;
    @(negedge clk);
    req_valid = 0; req_burst = 0;
    pr = 1; rdy_end = 0;
    while (lastcnt == 0 && n < 8000) begin
      logic s; s = w ? ctl[6] : ctl[5];
      if (!s && ctl[4:0] != 5'h10) abad++;
      if (!w && dbus_oe) obad++;
      if (pr && !s) strobes++;
      if (w && !pr && s) begin
        if (!dbus_oe || dbus_out != wpat(9'(wk))) wmis++;
        wk++;
      end
      if (done) begin
        dones++;
        if (w && dbus_oe) gapoe++;
        if (!w && rdata != dpat(base + dones - 1)) rmis++;
      end
      if (done_last) begin lastcnt++; lastpos = dones; rdy_end = req_ready; end
      else if (req_ready) rbad++;
      pr = s;
      @(negedge clk); n++;
    end
    check(strobes == BYTES && dones == BYTES, "R8 burst strobe count", strobes, BYTES);
    check(lastpos == BYTES, "R8 done_last on final byte", lastpos, BYTES);
    check(abad == 0, "R8 burst on data select", abad, 0);
    check(rbad == 0 && rdy_end, "R7 ready during/after burst", rbad, 0);
    if (w) begin
      check(wmis == 0 && wk == BYTES, "R9 burst write bytes by index", wmis, 0);
      check(gapoe == 0, "R5 oe low in done cycle between bytes", gapoe, 0);
    end else begin
      check(rmis == 0, "R8 burst read order", rmis, 0);
      check(obad == 0, "R6 no drive in burst read", obad, 0);
    end
  endtask

  initial begin
    #(5ns * 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_reads();
    t_writes();
    t_burst(1'b0);
    t_burst(1'b1);
    t_reads();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule